// File: doc/BRIEF.md
# Ordered Key-Word Access Gate

This block guards a protected information region. Software opens the region by writing three 32-bit key words, one after another and in a fixed order, to a write-only key register. After the last correct word the block raises a single access-enable output. Surrounding logic uses that output to qualify reads and writes of the protected region. While the gate is open, any further write to the key register closes it again.

The sequence tracker is forgiving in one way only. A word that does not match the expected next key sends the tracker back to its start. If that word happens to be the first key, it is taken as a new first step. Partial-byte writes never advance the sequence. Reads of the key register always return zero, so the key words cannot be recovered.

Top module: `keyseq_gate`

## Requirements
- R1: While reset is asserted, and on the first edge after it, `access_en` is 0. Reset also returns the tracker to its start, so progress made before reset is lost.
- R2: Full writes (`wr_strb` = 4'b1111) of 0x3A7F5CA3, then 0xA1E34F20, then 0x9608B2C1 set `access_en` to 1 on the clock edge that samples the third write.
- R3: Before the gate opens, a full write whose data is not the expected next key returns the tracker to its start. The keys that follow it then do not open the gate.
- R4: A mismatching full write whose data equals 0x3A7F5CA3 counts as the first step of a new sequence.
- R5: While `access_en` is 1, any write clears `access_en` on the edge that samples it and returns the tracker to its start. This holds even when the written data is the first key.
- R6: A write with any `wr_strb` bit at 0 is treated as a mismatch, whatever its data.
- R7: `rd_data` is zero in every cycle and in every state.
- R8: Cycles without `wr_en` leave `access_en` and the tracker's progress unchanged.
- R9: The keys written out of order (second or third key first) do not open the gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the key register |
| wr_strb | input | 4 | Byte-lane enables of the write |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the key register, always zero |
| access_en | output | 1 | High while the protected region is open |

## Verification
The assertions check on every cycle the rules that hold locally. These are: the gate closes after any write while open, it opens only on a write that hits the last key, idle cycles and partial writes never open it, and reset leaves it shut. The bench's scenarios are needed for the history-dependent behaviour. That covers recovery after a wrong word, a repeated first key being taken as step one, and a relocking first key not counting. It also covers progress being lost across reset and sequences spread over idle gaps.

// File: rtl/keyseq_pkg.sv
package keyseq_pkg;
  localparam int WORD_W = 32;
  localparam int NKEYS  = 3;
  // key i lives at bits [i*WORD_W +: WORD_W]; index 0 is written first
  localparam logic [NKEYS*WORD_W-1:0] KEY_CHAIN =
    {32'h9608B2C1, 32'hA1E34F20, 32'h3A7F5CA3};
endpackage

// File: rtl/keyseq_match.sv
module keyseq_match #(
  parameter int WORD_W = 32,
  parameter int NKEYS  = 3,
  parameter logic [NKEYS*WORD_W-1:0] KEYS = '0,
  localparam int STRB_W = WORD_W / 8
) (
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [WORD_W-1:0] wr_data,
  output logic [NKEYS-1:0]  hit
);
  logic full_word;
  assign full_word = &wr_strb;

  for (genvar i = 0; i < NKEYS; i++) begin : g_cmp
    assign hit[i] = full_word && (wr_data == KEYS[i*WORD_W +: WORD_W]);
  end
endmodule

// File: rtl/keyseq_tracker.sv
module keyseq_tracker #(
  parameter int NKEYS = 3,
  localparam int STEP_W = (NKEYS > 1) ? $clog2(NKEYS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NKEYS-1:0] hit,
  output logic             access_en
);
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NKEYS - 1);

  logic [STEP_W-1:0] step;

  always_ff @(posedge clk) begin
    if (rst) begin
      step      <= '0;
      access_en <= 1'b0;
    end else if (wr_en) begin
      if (access_en) begin
        access_en <= 1'b0;
        step      <= '0;
      end else if (hit[step]) begin
        if (step == LAST) begin
          access_en <= 1'b1;
          step      <= '0;
        end else begin
          step <= step + STEP_W'(1);
        end
      end else if (hit[0]) begin
        step <= (NKEYS > 1) ? STEP_W'(1) : '0;
      end else begin
        step <= '0;
      end
    end
  end

  // R2: the gate only opens on a write hitting the last key
  a_r2_open_on_last: assert property (@(posedge clk) disable iff (rst)
    $rose(access_en) |-> $past(wr_en && hit[NKEYS-1]));
  // R5: any write while open closes the gate
  a_r5_relock: assert property (@(posedge clk) disable iff (rst)
    (access_en && wr_en) |=> !access_en);
  // R3: tracker position stays inside the key list
  a_r3_step_range: assert property (@(posedge clk) disable iff (rst)
    step <= LAST);
  // R8: no write, no change
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(access_en) && $stable(step));
endmodule

// File: rtl/keyseq_gate.sv
module keyseq_gate #(
  parameter int WORD_W = keyseq_pkg::WORD_W,
  parameter int NKEYS  = keyseq_pkg::NKEYS,
  parameter logic [NKEYS*WORD_W-1:0] KEYS = keyseq_pkg::KEY_CHAIN,
  localparam int STRB_W = WORD_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [STRB_W-1:0] wr_strb,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              access_en
);
  logic [NKEYS-1:0] hit;

  keyseq_match #(.WORD_W(WORD_W), .NKEYS(NKEYS), .KEYS(KEYS)) u_match (
    .wr_strb (wr_strb),
    .wr_data (wr_data),
    .hit     (hit)
  );

  keyseq_tracker #(.NKEYS(NKEYS)) u_track (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .hit       (hit),
    .access_en (access_en)
  );

  // the key register is write-only; reads never expose it
  assign rd_data = '0;

  // R1: reset leaves the gate shut
  a_r1_reset_locked: assert property (@(posedge clk)
    rst |=> !access_en);
  // R6: a partial write can never open the gate
  a_r6_partial_no_open: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(&wr_strb) && !access_en) |=> !access_en);
endmodule

// File: tb/keyseq_gate_test.sv
module keyseq_gate_test;
  localparam logic [31:0] KA  = 32'h3A7F5CA3;
  localparam logic [31:0] KB  = 32'hA1E34F20;
  localparam logic [31:0] KC  = 32'h9608B2C1;
  localparam logic [31:0] BAD = 32'h12345678;
  localparam logic [3:0]  F   = 4'hF;
  localparam int NV = 30;

  // {expected access_en after the write, strobes, data}
  localparam logic [36:0] VEC [NV] = '{
    {1'b0, F, KA}, {1'b0, F, KB}, {1'b1, F, KC},             // R2
    {1'b0, F, KA}, {1'b0, F, KB}, {1'b0, F, KC},             // R5 relock with KA not counted
    {1'b0, F, KA}, {1'b0, F, BAD}, {1'b0, F, KB}, {1'b0, F, KC}, // R3
    {1'b0, F, KA}, {1'b0, F, KA}, {1'b0, F, KB}, {1'b1, F, KC},  // R4 repeated first key
    {1'b0, F, 32'h0},                                        // R5 relock
    {1'b0, F, KA}, {1'b0, F, KB}, {1'b0, F, KA}, {1'b0, F, KB}, {1'b1, F, KC}, // R4
    {1'b0, F, BAD},                                          // R5
    {1'b0, F, KA}, {1'b0, 4'h7, KB}, {1'b0, F, KC},          // R6
    {1'b0, F, KA}, {1'b0, F, KB}, {1'b0, 4'hE, KC}, {1'b0, F, KC}, // R6
    {1'b0, F, KB}, {1'b0, F, KC}                             // R9
  };

  logic clk = 0, rst = 1, wr_en = 0;
  logic [3:0] wr_strb = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic access_en;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  keyseq_gate uut (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_strb(wr_strb),
                   .wr_data(wr_data), .rd_data(rd_data), .access_en(access_en));

  function automatic string tag_of(int i);
    if (i < 3) return "R2";
    if (i < 6) return "R5";
    if (i < 10) return "R3";
    if (i < 14) return "R4";
    if (i < 15) return "R5";
    if (i < 20) return "R4";
    if (i < 21) return "R5";
    if (i < 28) return "R6";
    return "R9";
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] s, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_strb = s; wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_strb = '0; wr_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {31'd0, access_en}, 32'd0);
    check("R7", rd_data, 32'd0);
    rst = 0;

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][35:32], VEC[i][31:0]);
      check(tag_of(i), {31'd0, access_en}, {31'd0, VEC[i][36]});
      check("R7", rd_data, 32'd0);
    end

    // R8: idle gaps keep progress and the open state
    wr(F, KA); repeat (5) @(negedge clk);
    wr(F, KB); repeat (3) @(negedge clk);
    wr(F, KC);
    check("R8", {31'd0, access_en}, 32'd1);
    repeat (6) @(negedge clk);
    check("R8", {31'd0, access_en}, 32'd1);
    check("R7", rd_data, 32'd0);

    // R1: reset while open shuts the gate
    @(negedge clk); rst = 1;
    @(negedge clk);
    check("R1", {31'd0, access_en}, 32'd0);
    rst = 0;

    // R1: reset mid-sequence discards progress
    wr(F, KA); wr(F, KB);
    do_reset();
    wr(F, KC);
    check("R1", {31'd0, access_en}, 32'd0);
    wr(F, KA); wr(F, KB); wr(F, KC);
    check("R2", {31'd0, access_en}, 32'd1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #40000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule